// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptance Unit

This unit sits beside a CPU's execution pipeline. At each instruction boundary it decides whether a pending peripheral interrupt can be taken. Each request channel supplies a pending flag, an enable flag, a 3-bit priority level and a service-mode bit. The CPU supplies its global interrupt-enable bit and its current level mask.

When a channel qualifies, the unit picks one winner and emits a single-cycle accept pulse with the channel index and vector number. The route then depends on the channel's service-mode bit:
- Handler route: the unit steps the CPU through save, mask, stack-select and branch updates as a fixed series of load pulses.
- Service route: the unit launches an automatic I/O transfer service and waits for it to finish.

A software-interrupt strobe is taken whatever the enable bit and mask hold. A return strobe reloads mask, enable and stack-select from a shadow copy held outside the unit.

All outputs are plain pulses and levels with no back-pressure. The CPU must act on each load pulse in the cycle it appears. A strobe that arrives while the unit is busy is dropped and is not queued.

Top module: `intr_admit`

## Requirements
- R1: After reset, accept, save, every load pulse and the service-busy flag are all 0.
- R2: A hardware channel qualifies only when the global enable, its pending flag and its enable flag are all 1 and the level mask is strictly greater than its level; a mask equal to the level does not qualify.
- R3: Hardware requests are sampled only in cycles where the instruction-boundary strobe or the string-step strobe is 1.
- R4: Among qualifying channels, the numerically lowest level wins; on equal levels the lowest channel index wins. The vector equals VEC_BASE plus the winning index.
- R5: Handler route (service-mode bit 0): the cycle after sampling shows accept together with save request. The next three cycles show, in order, a mask load carrying the winner's level, a stack-select load of 1, and a vector load.
- R6: Service route (service-mode bit 1): the cycle after sampling shows accept with route-service at 1 and no save request. Service-busy stays 1 until the cycle after service-done is seen, and service-done is not looked at in the launch cycle.
- R7: While a handler, service, software or return sequence is in progress, every incoming strobe and request is ignored.
- R8: A software strobe is taken when idle even with the global enable at 0 or a mask of 0. The next cycle shows a save request with an enable load of value 0, and the cycle after shows a vector load carrying the software vector. It has priority over a hardware request in the same cycle.
- R9: A return strobe when idle gives, the next cycle, a mask, enable and stack-select load carrying the shadow values. It has priority over software and hardware requests.
- R10: Accept and every load pulse are one cycle wide, with one accept per acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gie_i | input | 1 | CPU global interrupt enable |
| ilm_i | input | 3 | CPU current level mask |
| req_i | input | NCH | Per-channel pending flags |
| en_i | input | NCH | Per-channel enable flags |
| mode_i | input | NCH | Per-channel service mode (1 = I/O service) |
| lvl_i | input | 3*NCH | Per-channel levels, channel k at bits 3k+2..3k |
| bnd_i | input | 1 | Instruction-boundary strobe |
| step_i | input | 1 | String-step boundary strobe |
| swi_i | input | 1 | Software interrupt strobe |
| sw_vec_i | input | VECW | Software interrupt vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| sh_mask_i | input | 3 | Shadow mask value |
| sh_ie_i | input | 1 | Shadow enable value |
| sh_stk_i | input | 1 | Shadow stack-select value |
| svc_done_i | input | 1 | I/O service finished (count exhausted or peripheral stop) |
| acc_o | output | 1 | Accept pulse |
| acc_chan_o | output | CHW | Accepted channel index |
| acc_vec_o | output | VECW | Accepted vector number |
| route_svc_o | output | 1 | With accept: 1 = I/O service, 0 = handler |
| svc_busy_o | output | 1 | I/O service in progress |
| save_req_o | output | 1 | Register save request pulse |
| mask_ld_o | output | 1 | Mask load pulse |
| mask_o | output | 3 | Mask value to load |
| ie_ld_o | output | 1 | Enable load pulse |
| ie_o | output | 1 | Enable value to load |
| stk_ld_o | output | 1 | Stack-select load pulse |
| stk_o | output | 1 | Stack-select value to load |
| vec_ld_o | output | 1 | Program bank and counter load pulse |
| vec_o | output | VECW | Vector to load |

## Verification
Several properties are checked in every cycle:
- the winner qualifies, and no qualifying channel has a lower level than it;
- the handler route follows its mask, stack and vector order;
- accept is one cycle wide;
- a software save is followed by a vector load;
- a running service does not raise accept or save.

Other behaviours can only be shown by the bench's scenarios:
- the strict mask comparison and the gating by the enable bits;
- sampling only on boundary or step strobes;
- strobe priority and the values carried by the loads;
- strobes being dropped while busy.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int LVL_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE,
    ST_MASK,
    ST_STK,
    ST_VEC,
    ST_LAUNCH,
    ST_SVC,
    ST_SWSAVE,
    ST_RET
  } seq_st_t;
endpackage

// File: rtl/intr_qualify.sv
module intr_qualify import intr_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic                 gie_i,
  input  logic [LVL_W-1:0]     ilm_i,
  input  logic [NCH-1:0]       req_i,
  input  logic [NCH-1:0]       en_i,
  input  logic [NCH*LVL_W-1:0] lvl_i,
  output logic [NCH-1:0]       qual_o
);
  // strict comparison: mask must exceed the channel level
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign qual_o[k] = gie_i & req_i[k] & en_i[k] & (ilm_i > lvl_i[k*LVL_W +: LVL_W]);
  end
endmodule

// File: rtl/intr_pick.sv
module intr_pick import intr_pkg::*; #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       qual_i,
  input  logic [NCH*LVL_W-1:0] lvl_i,
  output logic                 any_o,
  output logic [CHW-1:0]       idx_o,
  output logic [LVL_W-1:0]     win_lvl_o
);
  // strict less-than keeps the lowest index on equal levels
  always_comb begin
    any_o     = 1'b0;
    idx_o     = '0;
    win_lvl_o = '1;
    for (int i = 0; i < NCH; i++) begin
      if (qual_i[i] && (!any_o || (lvl_i[i*LVL_W +: LVL_W] < win_lvl_o))) begin
        any_o     = 1'b1;
        idx_o     = CHW'(i);
        win_lvl_o = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  // R4
  win_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> qual_i[idx_o]);

  for (genvar j = 0; j < NCH; j++) begin : g_prio
    // R4
    prio_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (any_o && qual_i[j]) |-> (lvl_i[j*LVL_W +: LVL_W] >= win_lvl_o));
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq import intr_pkg::*; #(
  parameter int NCH      = 4,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             hw_any_i,
  input  logic [CHW-1:0]   hw_idx_i,
  input  logic [LVL_W-1:0] hw_lvl_i,
  input  logic             hw_mode_i,
  input  logic             swi_i,
  input  logic [VECW-1:0]  sw_vec_i,
  input  logic             reti_i,
  input  logic [LVL_W-1:0] sh_mask_i,
  input  logic             sh_ie_i,
  input  logic             sh_stk_i,
  input  logic             svc_done_i,
  output logic             acc_o,
  output logic [CHW-1:0]   acc_chan_o,
  output logic [VECW-1:0]  acc_vec_o,
  output logic             route_svc_o,
  output logic             svc_busy_o,
  output logic             save_req_o,
  output logic             mask_ld_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             ie_ld_o,
  output logic             ie_o,
  output logic             stk_ld_o,
  output logic             stk_o,
  output logic             vec_ld_o,
  output logic [VECW-1:0]  vec_o
);
  seq_st_t          st_q, st_d;
  logic [CHW-1:0]   chan_q;
  logic [LVL_W-1:0] lvl_q, rmask_q;
  logic [VECW-1:0]  vec_q;
  logic             rie_q, rstk_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (reti_i)                  st_d = ST_RET;
        else if (swi_i)              st_d = ST_SWSAVE;
        else if (smp_i && hw_any_i)  st_d = hw_mode_i ? ST_LAUNCH : ST_SAVE;
      end
      ST_SAVE:   st_d = ST_MASK;
      ST_MASK:   st_d = ST_STK;
      ST_STK:    st_d = ST_VEC;
      ST_VEC:    st_d = ST_IDLE;
      ST_LAUNCH: st_d = ST_SVC;
      ST_SVC:    st_d = svc_done_i ? ST_IDLE : ST_SVC;
      ST_SWSAVE: st_d = ST_VEC;
      ST_RET:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      chan_q  <= '0;
      lvl_q   <= '0;
      vec_q   <= '0;
      rmask_q <= '0;
      rie_q   <= 1'b0;
      rstk_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        if (reti_i) begin
          rmask_q <= sh_mask_i;
          rie_q   <= sh_ie_i;
          rstk_q  <= sh_stk_i;
        end else if (swi_i) begin
          vec_q <= sw_vec_i;
        end else if (smp_i && hw_any_i) begin
          chan_q <= hw_idx_i;
          lvl_q  <= hw_lvl_i;
          vec_q  <= VECW'(VEC_BASE) + VECW'(hw_idx_i);
        end
      end
    end
  end

  assign acc_o       = (st_q == ST_SAVE) || (st_q == ST_LAUNCH);
  assign route_svc_o = (st_q == ST_LAUNCH);
  assign svc_busy_o  = (st_q == ST_LAUNCH) || (st_q == ST_SVC);
  assign save_req_o  = (st_q == ST_SAVE) || (st_q == ST_SWSAVE);
  assign mask_ld_o   = (st_q == ST_MASK) || (st_q == ST_RET);
  assign mask_o      = (st_q == ST_RET) ? rmask_q : lvl_q;
  assign ie_ld_o     = (st_q == ST_SWSAVE) || (st_q == ST_RET);
  assign ie_o        = (st_q == ST_RET) ? rie_q : 1'b0;
  assign stk_ld_o    = (st_q == ST_STK) || (st_q == ST_RET);
  assign stk_o       = (st_q == ST_RET) ? rstk_q : 1'b1;
  assign vec_ld_o    = (st_q == ST_VEC);
  assign vec_o       = vec_q;
  assign acc_chan_o  = chan_q;
  assign acc_vec_o   = vec_q;

  // R10
  acc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o);

  // R5
  hdl_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !route_svc_o) |=> mask_ld_o ##1 (stk_ld_o && stk_o) ##1 vec_ld_o);

  // R6
  svc_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && route_svc_o) |=> (svc_busy_o && !save_req_o));

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_busy_o && !svc_done_i) |=> (!acc_o && !save_req_o));

  // R8
  sw_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o && ie_ld_o) |=> vec_ld_o);
endmodule

// File: rtl/intr_admit.sv
module intr_admit import intr_pkg::*; #(
  parameter int NCH      = 4,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 gie_i,
  input  logic [LVL_W-1:0]     ilm_i,
  input  logic [NCH-1:0]       req_i,
  input  logic [NCH-1:0]       en_i,
  input  logic [NCH-1:0]       mode_i,
  input  logic [NCH*LVL_W-1:0] lvl_i,
  input  logic                 bnd_i,
  input  logic                 step_i,
  input  logic                 swi_i,
  input  logic [VECW-1:0]      sw_vec_i,
  input  logic                 reti_i,
  input  logic [LVL_W-1:0]     sh_mask_i,
  input  logic                 sh_ie_i,
  input  logic                 sh_stk_i,
  input  logic                 svc_done_i,
  output logic                 acc_o,
  output logic [CHW-1:0]       acc_chan_o,
  output logic [VECW-1:0]      acc_vec_o,
  output logic                 route_svc_o,
  output logic                 svc_busy_o,
  output logic                 save_req_o,
  output logic                 mask_ld_o,
  output logic [LVL_W-1:0]     mask_o,
  output logic                 ie_ld_o,
  output logic                 ie_o,
  output logic                 stk_ld_o,
  output logic                 stk_o,
  output logic                 vec_ld_o,
  output logic [VECW-1:0]      vec_o
);
  logic [NCH-1:0]   qual;
  logic             win_any;
  logic [CHW-1:0]   win_idx;
  logic [LVL_W-1:0] win_lvl;

  intr_qualify #(.NCH(NCH)) u_qualify (
    .gie_i (gie_i),
    .ilm_i (ilm_i),
    .req_i (req_i),
    .en_i  (en_i),
    .lvl_i (lvl_i),
    .qual_o(qual)
  );

  intr_pick #(.NCH(NCH)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qual_i   (qual),
    .lvl_i    (lvl_i),
    .any_o    (win_any),
    .idx_o    (win_idx),
    .win_lvl_o(win_lvl)
  );

  intr_seq #(.NCH(NCH), .VECW(VECW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (bnd_i | step_i),
    .hw_any_i   (win_any),
    .hw_idx_i   (win_idx),
    .hw_lvl_i   (win_lvl),
    .hw_mode_i  (mode_i[win_idx]),
    .swi_i      (swi_i),
    .sw_vec_i   (sw_vec_i),
    .reti_i     (reti_i),
    .sh_mask_i  (sh_mask_i),
    .sh_ie_i    (sh_ie_i),
    .sh_stk_i   (sh_stk_i),
    .svc_done_i (svc_done_i),
    .acc_o      (acc_o),
    .acc_chan_o (acc_chan_o),
    .acc_vec_o  (acc_vec_o),
    .route_svc_o(route_svc_o),
    .svc_busy_o (svc_busy_o),
    .save_req_o (save_req_o),
    .mask_ld_o  (mask_ld_o),
    .mask_o     (mask_o),
    .ie_ld_o    (ie_ld_o),
    .ie_o       (ie_o),
    .stk_ld_o   (stk_ld_o),
    .stk_o      (stk_o),
    .vec_ld_o   (vec_ld_o),
    .vec_o      (vec_o)
  );

  // R2
  mask_strict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_any |-> (ilm_i > win_lvl) && gie_i);
endmodule

// File: tb/test_intr_admit.sv
module test_intr_admit;
  localparam int NCH = 4;
  localparam int VECW = 8;
  localparam int VEC_BASE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gie = 1'b0;
  logic [2:0] ilm = '0;
  logic [NCH-1:0] req = '0, en = '0, mode = '0;
  logic [NCH*3-1:0] lvl = '0;
  logic bnd = 1'b0, step = 1'b0, swi = 1'b0, reti = 1'b0, svc_done = 1'b0;
  logic [VECW-1:0] sw_vec = '0;
  logic [2:0] sh_mask = '0;
  logic sh_ie = 1'b0, sh_stk = 1'b0;

  logic acc, route, busy, save, mld, ield, ieo, sld, stko, vld;
  logic [1:0] chan;
  logic [VECW-1:0] avec, vec;
  logic [2:0] mask;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  intr_admit #(.NCH(NCH), .VECW(VECW), .VEC_BASE(VEC_BASE)) i_intr_admit (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .ilm_i(ilm), .req_i(req), .en_i(en),
    .mode_i(mode), .lvl_i(lvl), .bnd_i(bnd), .step_i(step), .swi_i(swi),
    .sw_vec_i(sw_vec), .reti_i(reti), .sh_mask_i(sh_mask), .sh_ie_i(sh_ie),
    .sh_stk_i(sh_stk), .svc_done_i(svc_done), .acc_o(acc), .acc_chan_o(chan),
    .acc_vec_o(avec), .route_svc_o(route), .svc_busy_o(busy), .save_req_o(save),
    .mask_ld_o(mld), .mask_o(mask), .ie_ld_o(ield), .ie_o(ieo), .stk_ld_o(sld),
    .stk_o(stko), .vec_ld_o(vld), .vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulses(input string tag, input int a, input int s, input int m,
                        input int i, input int k, input int v, input int b);
    chk({tag, " acc"}, int'(acc), a);
    chk({tag, " save"}, int'(save), s);
    chk({tag, " mask_ld"}, int'(mld), m);
    chk({tag, " ie_ld"}, int'(ield), i);
    chk({tag, " stk_ld"}, int'(sld), k);
    chk({tag, " vec_ld"}, int'(vld), v);
    chk({tag, " busy"}, int'(busy), b);
  endtask

  function automatic int ref_pick();
    int best = -1;
    int blv = 8;
    for (int i = 0; i < NCH; i++) begin
      int lv = int'(lvl[i*3 +: 3]);
      if (gie && req[i] && en[i] && (int'(ilm) > lv) && (lv < blv)) begin
        best = i;
        blv = lv;
      end
    end
    return best;
  endfunction

  task automatic noise();
    bnd = 1'b1; step = 1'b1; req = '1; en = '1; gie = 1'b1; ilm = 3'd7;
    swi = 1'($urandom % 2); reti = 1'($urandom % 2);
  endtask

  // apply current inputs for one edge, then follow and check the sequence
  task automatic run_one(input string tag);
    int w = ref_pick();
    bit smp = bnd || step;
    bit do_ret = reti, do_sw = swi;
    logic [2:0] e_mask = sh_mask;
    logic e_ie = sh_ie, e_stk = sh_stk;
    logic [VECW-1:0] e_swv = sw_vec;
    int wl = (w >= 0) ? int'(lvl[w*3 +: 3]) : 0;
    bit wm = (w >= 0) ? mode[w] : 1'b0;
    @(negedge clk);
    if (do_ret) begin
      pulses({tag, " R9 ret"}, 0, 0, 1, 1, 1, 0, 0);
      chk({tag, " R9 mask"}, int'(mask), int'(e_mask));
      chk({tag, " R9 ie"}, int'(ieo), int'(e_ie));
      chk({tag, " R9 stk"}, int'(stko), int'(e_stk));
      noise();
      @(negedge clk);
      pulses({tag, " R7 after ret"}, 0, 0, 0, 0, 0, 0, 0);
    end else if (do_sw) begin
      pulses({tag, " R8 sw save"}, 0, 1, 0, 1, 0, 0, 0);
      chk({tag, " R8 ie value"}, int'(ieo), 0);
      noise();
      @(negedge clk);
      pulses({tag, " R8 sw vec"}, 0, 0, 0, 0, 0, 1, 0);
      chk({tag, " R8 vec value"}, int'(vec), int'(e_swv));
      @(negedge clk);
      pulses({tag, " R7 after sw"}, 0, 0, 0, 0, 0, 0, 0);
    end else if (smp && w >= 0) begin
      chk({tag, " R4 chan"}, int'(chan), w);
      chk({tag, " R4 vec"}, int'(avec), VEC_BASE + w);
      if (wm) begin
        pulses({tag, " R6 launch"}, 1, 0, 0, 0, 0, 0, 1);
        chk({tag, " R6 route"}, int'(route), 1);
        noise(); svc_done = 1'b1;  // ignored in launch cycle
        @(negedge clk);
        svc_done = 1'b0;
        pulses({tag, " R6 running"}, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < int'($urandom % 3); k++) begin
          @(negedge clk);
          pulses({tag, " R7 svc busy"}, 0, 0, 0, 0, 0, 0, 1);
        end
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        pulses({tag, " R6 done"}, 0, 0, 0, 0, 0, 0, 0);
      end else begin
        pulses({tag, " R5 save"}, 1, 1, 0, 0, 0, 0, 0);
        chk({tag, " R5 route"}, int'(route), 0);
        noise();
        @(negedge clk);
        pulses({tag, " R5 mask"}, 0, 0, 1, 0, 0, 0, 0);
        chk({tag, " R5 mask value"}, int'(mask), wl);
        @(negedge clk);
        pulses({tag, " R5 stk"}, 0, 0, 0, 0, 1, 0, 0);
        chk({tag, " R5 stk value"}, int'(stko), 1);
        @(negedge clk);
        pulses({tag, " R5 vec"}, 0, 0, 0, 0, 0, 1, 0);
        chk({tag, " R5 vec value"}, int'(vec), VEC_BASE + w);
        @(negedge clk);
        pulses({tag, " R10 R7 idle"}, 0, 0, 0, 0, 0, 0, 0);
      end
    end else begin
      pulses({tag, " R2 R3 none"}, 0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic quiet();
    bnd = 0; step = 0; swi = 0; reti = 0; svc_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses("R1 reset", 0, 0, 0, 0, 0, 0, 0);

    // R2: mask equal to level does not qualify
    quiet(); gie = 1; ilm = 3'd4; req = 4'b0001; en = 4'b0001; mode = 0;
    lvl = {3'd0, 3'd0, 3'd0, 3'd4}; bnd = 1;
    run_one("R2 equal");
    // R2: enable flag off blocks
    quiet(); gie = 1; ilm = 3'd7; req = 4'b0010; en = 4'b0000; bnd = 1;
    run_one("R2 en off");
    // R2: global enable off blocks
    quiet(); gie = 0; ilm = 3'd7; req = 4'b1111; en = 4'b1111; bnd = 1;
    run_one("R2 gie off");
    // R3: no strobe, nothing sampled
    quiet(); gie = 1; ilm = 3'd7; req = 4'b1111; en = 4'b1111;
    run_one("R3 no strobe");
    // R3 + R4: string step strobe, tie on level goes to lowest index
    quiet(); gie = 1; ilm = 3'd7; req = 4'b1110; en = 4'b1111; mode = 0;
    lvl = {3'd2, 3'd5, 3'd2, 3'd1}; step = 1;
    run_one("R3 R4 tie");
    // R4: lowest level wins over lower index
    quiet(); gie = 1; ilm = 3'd6; req = 4'b1111; en = 4'b1111; mode = 4'b1000;
    lvl = {3'd0, 3'd3, 3'd3, 3'd5}; bnd = 1;
    run_one("R4 R6 level");
    // R8: software taken with gie 0 and mask 0, beats hardware
    quiet(); gie = 0; ilm = 3'd0; swi = 1; sw_vec = 8'hA5; bnd = 1;
    run_one("R8 sw");
    quiet(); gie = 1; ilm = 3'd7; req = 4'b0001; en = 4'b0001; lvl = '0;
    swi = 1; sw_vec = 8'h3C; bnd = 1;
    run_one("R8 sw over hw");
    // R9: return beats software and hardware
    quiet(); reti = 1; swi = 1; bnd = 1; sh_mask = 3'd5; sh_ie = 1; sh_stk = 0;
    run_one("R9 ret");

    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 16);
      quiet();
      gie = ($urandom % 4) != 0;
      ilm = 3'($urandom);
      req = 4'($urandom); en = 4'($urandom); mode = 4'($urandom);
      lvl = 12'($urandom);
      bnd = 1'($urandom % 2); step = ($urandom % 4) == 0;
      reti = (r == 0); swi = (r == 1);
      sw_vec = 8'($urandom);
      sh_mask = 3'($urandom); sh_ie = 1'($urandom); sh_stk = 1'($urandom);
      run_one("rand");
    end
    quiet();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule